// File: doc/BRIEF.md
# Pipelined Converter Stage Code Aligner

A three-stage pipelined analog-to-digital converter hands its digital result over one stage at a time: the first stage decides on a sample, passes an amplified residue on, and the later stages decide on that same sample one and two clock cycles afterwards. Each stage's binary code therefore shows up on a different clock. This block lines the three codes of a single sample up in time and joins them into one converter word.

The first and second stages resolve three bits each and the last resolves two, eight bits in all, with no redundant bits. The codes are concatenated directly, with no overlap-add correction. The first-stage code is held back by two clocks and the second-stage code by one clock, so all three match the code now arriving from the last stage. The joined word is registered and comes with a valid flag. After reset the flag stays low until the delay lines hold only samples taken after reset. From then on it is high on every clock.

Stage widths and the lag of each stage are parameters. A lag of zero turns that stage's delay line into a plain wire. The block runs on one clock at the sample rate and has a synchronous, active-high reset.

Top module: `stage_code_aligner`

## Requirements
- R1: On the clock after a reset edge, `word_valid` is 0 and `word_out` is 0.
- R2: After reset is released, `word_valid` stays 0 for the first two rising edges. It becomes 1 on the third rising edge and stays 1 on every later edge until reset is asserted again.
- R3: When `word_valid` is 1, `word_out[7:5]` equals the `st1_code` value sampled three rising edges earlier. That is two edges before the stage-3 code it is paired with.
- R4: When `word_valid` is 1, `word_out[4:2]` equals the `st2_code` value sampled two rising edges earlier.
- R5: When `word_valid` is 1, `word_out[1:0]` equals the `st3_code` value sampled on the previous rising edge. This is the block's one-clock output latency.
- R6: Whenever `word_valid` is 0, `word_out` is 0.
- R7: A reset asserted in the middle of a stream clears the held codes. After release the fill sequence of R2 starts over, and no code sampled before the reset ever reaches `word_out`.
- R8: Every code value passes through unchanged, including all-zeros and all-ones codes in each field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| st1_code | input | 3 | Binary code of stage 1 (earliest decision) |
| st2_code | input | 3 | Binary code of stage 2 |
| st3_code | input | 2 | Binary code of stage 3 (latest decision) |
| word_out | output | 8 | Aligned converter word, stage 1 in the top bits |
| word_valid | output | 1 | High when `word_out` holds a fully aligned sample |

## Verification
On every cycle the assertions check three things:
- the valid flag against a count of edges since reset,
- the zero word whenever the flag is low,
- each field of the word against the matching input sampled the right number of edges earlier.

Only the bench's scenarios can show the rest: that a reset in mid-stream leaves no stale code behind, that the first valid word pairs the first three post-reset samples correctly, and that every value of every field passes through. The bench covers these with an exhaustive sweep and with random code streams, which it compares against a queue-based model.

// File: rtl/sca_pkg.sv
package sca_pkg;

   // Largest of three non-negative lags.
   function automatic int lag_max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

   // Bits needed to count from 0 up to and including n (at least 1).
   function automatic int count_bits(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/sca_delay_line.sv
module sca_delay_line #(
   parameter int WIDTH = 3,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_shift
         logic [WIDTH-1:0] taps [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
            end else begin
               taps[0] <= din;
               for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
            end
         end

         assign dout = taps[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/sca_fill_ctr.sv
module sca_fill_ctr #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst,
   output logic full
);
   import sca_pkg::*;

   localparam int CW = count_bits(LIMIT);

   generate
      if (LIMIT == 0) begin : g_none
         assign full = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)                          cnt_q <= '0;
            else if (cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
         end

         assign full = (cnt_q == CW'(LIMIT));
      end
   endgenerate

endmodule

// File: rtl/stage_code_aligner.sv
module stage_code_aligner #(
   parameter int S1_W   = 3,
   parameter int S2_W   = 3,
   parameter int S3_W   = 2,
   parameter int S1_LAG = 2,
   parameter int S2_LAG = 1,
   parameter int S3_LAG = 0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [S1_W-1:0]            st1_code,
   input  logic [S2_W-1:0]            st2_code,
   input  logic [S3_W-1:0]            st3_code,
   output logic [S1_W+S2_W+S3_W-1:0]  word_out,
   output logic                       word_valid
);
   import sca_pkg::*;

   localparam int WORD_W  = S1_W + S2_W + S3_W;
   localparam int MAX_LAG = lag_max3(S1_LAG, S2_LAG, S3_LAG);

   initial begin
      assert (S1_W > 0 && S2_W > 0 && S3_W > 0)
         else $error("stage_code_aligner: stage widths must be positive");
      assert (S1_LAG >= 0 && S2_LAG >= 0 && S3_LAG >= 0)
         else $error("stage_code_aligner: lags must not be negative");
      assert (S1_LAG >= S2_LAG && S2_LAG >= S3_LAG)
         else $error("stage_code_aligner: earlier stages need the longer lag");
      assert (MAX_LAG < 1024)
         else $error("stage_code_aligner: lag out of range");
   end

   logic [S1_W-1:0] st1_al;
   logic [S2_W-1:0] st2_al;
   logic [S3_W-1:0] st3_al;
   logic            filled;

   sca_delay_line #(.WIDTH(S1_W), .DEPTH(S1_LAG)) u_dl1 (
      .clk(clk), .rst(rst), .din(st1_code), .dout(st1_al)
   );

   sca_delay_line #(.WIDTH(S2_W), .DEPTH(S2_LAG)) u_dl2 (
      .clk(clk), .rst(rst), .din(st2_code), .dout(st2_al)
   );

   sca_delay_line #(.WIDTH(S3_W), .DEPTH(S3_LAG)) u_dl3 (
      .clk(clk), .rst(rst), .din(st3_code), .dout(st3_al)
   );

   sca_fill_ctr #(.LIMIT(MAX_LAG)) u_fill (
      .clk(clk), .rst(rst), .full(filled)
   );

   logic [WORD_W-1:0] joined;
   assign joined = {st1_al, st2_al, st3_al};

   always_ff @(posedge clk) begin
      if (rst) begin
         word_out   <= '0;
         word_valid <= 1'b0;
      end else begin
         word_out   <= filled ? joined : '0;
         word_valid <= filled;
      end
   end

endmodule

// File: rtl/sca_checker.sv
module sca_checker #(
   parameter int S1_W   = 3,
   parameter int S2_W   = 3,
   parameter int S3_W   = 2,
   parameter int S1_LAG = 2,
   parameter int S2_LAG = 1,
   parameter int S3_LAG = 0
) (
   input logic                      clk,
   input logic                      rst,
   input logic [S1_W-1:0]           st1_code,
   input logic [S2_W-1:0]           st2_code,
   input logic [S3_W-1:0]           st3_code,
   input logic [S1_W+S2_W+S3_W-1:0] word_out,
   input logic                      word_valid
);
   import sca_pkg::*;

   localparam int MAX_LAG = lag_max3(S1_LAG, S2_LAG, S3_LAG);
   localparam int W3 = S3_W;
   localparam int W2 = S2_W + S3_W;
   localparam int WA = S1_W + S2_W + S3_W;

   logic [15:0] edges_q;
   always_ff @(posedge clk) begin
      if (rst)                    edges_q <= '0;
      else if (edges_q != 16'hFFFF) edges_q <= edges_q + 1'b1;
   end

   // R1
   rst_clears_chk: assert property (@(posedge clk)
      rst |=> (!word_valid && word_out == '0));

   // R2
   fill_timing_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid == (32'(edges_q) > MAX_LAG));

   // R2
   valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> word_valid);

   // R6
   masked_word_chk: assert property (@(posedge clk) disable iff (rst)
      !word_valid |-> word_out == '0);

   generate
      if (S1_LAG == 2 && S2_LAG == 1 && S3_LAG == 0) begin : g_fields
         // R3
         stage1_field_chk: assert property (@(posedge clk) disable iff (rst)
            word_valid |-> word_out[WA-1:W2] == $past(st1_code, 3));
         // R4
         stage2_field_chk: assert property (@(posedge clk) disable iff (rst)
            word_valid |-> word_out[W2-1:W3] == $past(st2_code, 2));
         // R5
         stage3_field_chk: assert property (@(posedge clk) disable iff (rst)
            word_valid |-> word_out[W3-1:0] == $past(st3_code, 1));
      end
   endgenerate

endmodule

bind stage_code_aligner sca_checker #(
   .S1_W(S1_W), .S2_W(S2_W), .S3_W(S3_W),
   .S1_LAG(S1_LAG), .S2_LAG(S2_LAG), .S3_LAG(S3_LAG)
) chk (
   .clk(clk), .rst(rst),
   .st1_code(st1_code), .st2_code(st2_code), .st3_code(st3_code),
   .word_out(word_out), .word_valid(word_valid)
);

// File: tb/stage_code_aligner_test.sv
module stage_code_aligner_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] st1_code = '0;
   logic [2:0] st2_code = '0;
   logic [1:0] st3_code = '0;
   logic [7:0] word_out;
   logic       word_valid;

   stage_code_aligner uut (
      .clk(clk), .rst(rst),
      .st1_code(st1_code), .st2_code(st2_code), .st3_code(st3_code),
      .word_out(word_out), .word_valid(word_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Reference model state
   logic [2:0] h1[$];
   logic [2:0] h2[$];
   logic [1:0] h3[$];
   int         post_edges = 0;
   logic [7:0] exp_word = '0;
   logic       exp_valid = 1'b0;

   // Values that the last rising edge sampled
   logic       cur_rst = 1'b1;
   logic [2:0] cur1 = '0;
   logic [2:0] cur2 = '0;
   logic [1:0] cur3 = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Advance the model by the edge that has just passed
   task automatic model_step();
      if (cur_rst) begin
         h1.delete(); h2.delete(); h3.delete();
         post_edges = 0;
         exp_word = '0;
         exp_valid = 1'b0;
      end else begin
         h1.push_front(cur1); h2.push_front(cur2); h3.push_front(cur3);
         if (h1.size() > 4) void'(h1.pop_back());
         if (h2.size() > 4) void'(h2.pop_back());
         if (h3.size() > 4) void'(h3.pop_back());
         post_edges++;
         if (post_edges >= 3) begin
            exp_valid = 1'b1;
            exp_word = {h1[2], h2[1], h3[0]};
         end else begin
            exp_valid = 1'b0;
            exp_word = '0;
         end
      end
   endtask

   task automatic compare_outputs();
      check(word_valid === exp_valid, "R2/R7", "valid", {7'd0, word_valid}, {7'd0, exp_valid});
      if (!exp_valid)
         check(word_out === 8'h00, "R6", "masked word", word_out, 8'h00);
      else begin
         check(word_out[7:5] === exp_word[7:5], "R3", "stage1 field", {5'd0, word_out[7:5]}, {5'd0, exp_word[7:5]});
         check(word_out[4:2] === exp_word[4:2], "R4", "stage2 field", {5'd0, word_out[4:2]}, {5'd0, exp_word[4:2]});
         check(word_out[1:0] === exp_word[1:0], "R5/R8", "stage3 field", {6'd0, word_out[1:0]}, {6'd0, exp_word[1:0]});
      end
   endtask

   // One clock: at the falling edge, check the result of the last rising edge, then drive new inputs
   task automatic cycle(input logic r, input logic [2:0] a, input logic [2:0] b, input logic [1:0] c);
      @(negedge clk);
      model_step();
      compare_outputs();
      rst = r; st1_code = a; st2_code = b; st3_code = c;
      cur_rst = r; cur1 = a; cur2 = b; cur3 = c;
   endtask

   initial begin
      // Reset for two edges
      cycle(1'b1, 3'd7, 3'd7, 2'd3);
      cycle(1'b1, 3'd7, 3'd7, 2'd3);
      // R1: directed reset check
      check(word_valid === 1'b0 && word_out === 8'h00, "R1", "reset state",
            word_out, 8'h00);

      // R8: exhaustive sweep of every code value in every field
      for (int i = 0; i < 256; i++)
         cycle(1'b0, i[7:5], i[4:2], i[1:0]);

      // R7: reset mid-stream with all-ones codes held in the lines
      cycle(1'b0, 3'd7, 3'd7, 2'd3);
      cycle(1'b0, 3'd7, 3'd7, 2'd3);
      cycle(1'b1, 3'd5, 3'd5, 2'd1);
      cycle(1'b0, 3'd1, 3'd2, 2'd1);
      check(word_valid === 1'b0, "R7", "valid after mid reset", {7'd0, word_valid}, 8'h00);
      cycle(1'b0, 3'd2, 3'd3, 2'd2);
      check(word_valid === 1'b0 && word_out === 8'h00, "R7", "no stale code", word_out, 8'h00);
      cycle(1'b0, 3'd3, 3'd4, 2'd3);
      cycle(1'b0, 3'd0, 3'd0, 2'd0);
      // R2/R3/R4/R5: first valid word pairs the first three post-reset samples
      check(word_out === {3'd1, 3'd3, 2'd3} && word_valid, "R3", "first aligned word",
            word_out, {3'd1, 3'd3, 2'd3});

      // Random stream with occasional resets
      for (int i = 0; i < 600; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         cycle((rv[31:26] == 6'd0), rv[2:0], rv[5:3], rv[7:6]);
      end

      // Long reset, then restart
      for (int i = 0; i < 5; i++) cycle(1'b1, 3'd6, 3'd6, 2'd2);
      for (int i = 0; i < 20; i++) cycle(1'b0, 3'(i), 3'(i + 3), 2'(i));
      cycle(1'b0, 3'd0, 3'd0, 2'd0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule